// File: doc/BRIEF.md
# Masked Multichannel Scan Sequencer

This block runs one acquisition scan per trigger pulse. At the trigger it captures a channel enable mask and a free-running 64-bit time counter. It then visits the enabled channels from index 0 upward. For each one it asks an external conversion frame engine for a sample over a level request/done handshake. Each 16-bit result goes out on a valid/ready word stream.

Channels whose mask bit is clear produce no frame-engine transaction and no word, so each record is compacted. After the last sample come four timestamp words, most significant first. The final word carries the last flag. A trigger that arrives while a scan is in progress starts nothing and only increments an overrun counter.

The controller is a five-state machine:
- IDLE waits for a trigger (IDLE→SEEK on trigger).
- SEEK picks the lowest remaining enabled channel (SEEK→CONV when one remains, SEEK→STAMP when none remains).
- CONV holds the request (CONV→SEND on done).
- SEND offers the sample word (SEND→SEEK on ready).
- STAMP offers the timestamp words (STAMP→STAMP on ready for the first three words, STAMP→IDLE on ready for the fourth).

Top module: `scan_sequencer`

## Requirements
- R1: After reset, `out_valid_o` and `conv_req_o` are low and `overrun_cnt_o` is 0.
- R2: Within one scan, conversions are requested only for channels whose bit in the latched mask is 1 (bit i enables channel i). They are requested in strictly ascending channel order, exactly once each.
- R3: Each sample word equals the 16-bit value present on `conv_data_i` when `conv_done_i` ended that channel's request. The word is unchanged, with bit 15 the most significant.
- R4: After the samples of a scan, four timestamp words follow. They are bits 63:48, 47:32, 31:16 and 15:0 of `tstamp_i`, in that order, as sampled on the clock edge that accepts the trigger.
- R5: `out_last_o` is 1 on the fourth timestamp word of each record and 0 on every other word.
- R6: With an all-zero mask, a trigger yields no conversion request and a record of only the four timestamp words.
- R7: A trigger accepted while a scan is in progress starts no extra record. It increments `overrun_cnt_o` by one, wrapping at its width.
- R8: Changes to `chan_mask_i` after the trigger edge do not change the current record.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_data_o` and `out_last_o` hold their values into the next cycle.
- R10: Once raised, `conv_req_o` stays high with a stable `conv_chan_o` until a cycle with `conv_done_i` high. It is never high while `out_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Scan start pulse |
| chan_mask_i | input | 8 | Channel enable mask, bit i for channel i |
| tstamp_i | input | 64 | Free-running time counter |
| conv_req_o | output | 1 | Conversion request to the frame engine |
| conv_chan_o | output | 3 | Channel index of the current request |
| conv_done_i | input | 1 | Conversion complete, data valid |
| conv_data_i | input | 16 | Conversion result |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 16 | Output word |
| out_last_o | output | 1 | Final word of the record |
| out_ready_i | input | 1 | Downstream accepts the word |
| overrun_cnt_o | output | 8 | Count of triggers ignored during a scan |

## Verification
The patterns are chosen so that each one isolates a different fault:
- A full mask and an alternating mask (0xA5) separate correct skipping of disabled channels from a plain index walk.
- Single-channel masks at both ends (0x01, 0x80) expose off-by-one errors in the search and in the last-flag placement.
- An all-zero mask checks the timestamp-only record.
- Changing the mask just after the trigger tells a latched mask apart from a live one.
- A second trigger during a slow conversion separates overrun counting from a restarted scan.
- Each sample embeds its channel and scan tag, and downstream readiness is throttled on some scans, so mis-ordering, stale data and dropped words under backpressure all show up as value mismatches.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SEEK,
        SQ_CONV,
        SQ_SEND,
        SQ_STAMP
    } sq_state_t;

endpackage

// File: rtl/scan_ch_pick.sv
// Lowest-index set bit of the remaining mask.
module scan_ch_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] mask_i,
    output logic              any_o,
    output logic [CH_W-1:0]   idx_o
);

    always_comb begin
        any_o = |mask_i;
        idx_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/scan_ts_shift.sv
// Timestamp holding register, unloaded most significant word first.
module scan_ts_shift #(
    parameter int TS_W   = 64,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [TS_W-1:0]   ts_i,
    output logic [WORD_W-1:0] word_o
);

    logic [TS_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_i) begin
            hold_q <= ts_i;
        end else if (shift_i) begin
            hold_q <= {hold_q[TS_W-WORD_W-1:0], {WORD_W{1'b0}}};
        end
    end

    assign word_o = hold_q[TS_W-1 -: WORD_W];

endmodule

// File: rtl/scan_ovr_count.sv
// Wrapping count of ignored triggers.
module scan_ovr_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (hit_i) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 16,
    parameter int TS_W     = 64,
    parameter int OVR_W    = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_i,
    input  logic [NUM_CH-1:0]   chan_mask_i,
    input  logic [TS_W-1:0]     tstamp_i,
    output logic                conv_req_o,
    output logic [CH_W-1:0]     conv_chan_o,
    input  logic                conv_done_i,
    input  logic [SAMPLE_W-1:0] conv_data_i,
    output logic                out_valid_o,
    output logic [SAMPLE_W-1:0] out_data_o,
    output logic                out_last_o,
    input  logic                out_ready_i,
    output logic [OVR_W-1:0]    overrun_cnt_o
);

    localparam int TS_WORDS = TS_W / SAMPLE_W;
    localparam int WC_W     = (TS_WORDS > 1) ? $clog2(TS_WORDS) : 1;

    sq_state_t st_q, st_nxt;

    logic [NUM_CH-1:0]   mask_q;
    logic [CH_W-1:0]     chan_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic [WC_W-1:0]     wcnt_q;

    logic                pick_any;
    logic [CH_W-1:0]     pick_idx;
    logic [SAMPLE_W-1:0] ts_word;
    logic                ts_final;
    logic                ts_load;
    logic                ts_shift;
    logic                scan_busy;

    assign ts_final  = (wcnt_q == WC_W'(TS_WORDS - 1));
    assign scan_busy = (st_q != SQ_IDLE);
    assign ts_load   = (st_q == SQ_IDLE) && trig_i;
    assign ts_shift  = (st_q == SQ_STAMP) && out_ready_i && !ts_final;

    scan_ch_pick #(.NUM_CH(NUM_CH)) u_pick (
        .mask_i (mask_q),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    scan_ts_shift #(.TS_W(TS_W), .WORD_W(SAMPLE_W)) u_ts (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ts_load),
        .shift_i (ts_shift),
        .ts_i    (tstamp_i),
        .word_o  (ts_word)
    );

    scan_ovr_count #(.CNT_W(OVR_W)) u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (trig_i && scan_busy),
        .count_o (overrun_cnt_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            SQ_IDLE:  if (trig_i) st_nxt = SQ_SEEK;
            SQ_SEEK:  st_nxt = pick_any ? SQ_CONV : SQ_STAMP;
            SQ_CONV:  if (conv_done_i) st_nxt = SQ_SEND;
            SQ_SEND:  if (out_ready_i) st_nxt = SQ_SEEK;
            SQ_STAMP: if (out_ready_i && ts_final) st_nxt = SQ_IDLE;
            default:  st_nxt = SQ_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            chan_q   <= '0;
            sample_q <= '0;
            wcnt_q   <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (trig_i) mask_q <= chan_mask_i;
                end
                SQ_SEEK: begin
                    chan_q <= pick_idx;
                    wcnt_q <= '0;
                end
                SQ_CONV: begin
                    if (conv_done_i) begin
                        sample_q       <= conv_data_i;
                        mask_q[chan_q] <= 1'b0;
                    end
                end
                SQ_STAMP: begin
                    if (ts_shift) wcnt_q <= wcnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        conv_req_o  = (st_q == SQ_CONV);
        conv_chan_o = chan_q;
        out_valid_o = (st_q == SQ_SEND) || (st_q == SQ_STAMP);
        out_data_o  = (st_q == SQ_SEND) ? sample_q : ts_word;
        out_last_o  = (st_q == SQ_STAMP) && ts_final;
    end

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 16,
    parameter int OVR_W    = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                trig_i,
    input logic                busy,
    input logic                conv_req_o,
    input logic [CH_W-1:0]     conv_chan_o,
    input logic                conv_done_i,
    input logic                out_valid_o,
    input logic [SAMPLE_W-1:0] out_data_o,
    input logic                out_last_o,
    input logic                out_ready_i,
    input logic [OVR_W-1:0]    overrun_cnt_o
);

    a_r9_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=>
            out_valid_o && $stable(out_data_o) && $stable(out_last_o));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o && !conv_done_i |=> conv_req_o && $stable(conv_chan_o));

    a_r10_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_req_o && out_valid_o));

    a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

    a_r7_ovr_step: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i && busy |=> overrun_cnt_o == $past(overrun_cnt_o) + 1'b1);

    a_r7_ovr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_i && busy) |=> $stable(overrun_cnt_o));

endmodule

bind scan_sequencer scan_sequencer_chk #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .OVR_W    (OVR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_i        (trig_i),
    .busy          (scan_busy),
    .conv_req_o    (conv_req_o),
    .conv_chan_o   (conv_chan_o),
    .conv_done_i   (conv_done_i),
    .out_valid_o   (out_valid_o),
    .out_data_o    (out_data_o),
    .out_last_o    (out_last_o),
    .out_ready_i   (out_ready_i),
    .overrun_cnt_o (overrun_cnt_o)
);

// File: tb/scan_sequencer_test.sv
`timescale 1ns/1ps
module scan_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [7:0]  chan_mask = '0;
    logic [63:0] tstamp = 64'hF0E1_D2C3_B4A5_0000;
    logic        conv_req;
    logic [2:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic [7:0]  ovr_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int scan_tag = 0;
    int fe_lat = 0;
    int fe_wait = 0;
    int req_count = 0;
    int last_chan = -1;
    int rdy_mode = 0;
    logic        hold_pend = 1'b0;
    logic [16:0] hold_word = '0;
    logic [16:0] exp_q[$];

    always #4 clk = ~clk;

    always @(negedge clk) tstamp <= tstamp + 64'd1;

    scan_sequencer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_i        (trig),
        .chan_mask_i   (chan_mask),
        .tstamp_i      (tstamp),
        .conv_req_o    (conv_req),
        .conv_chan_o   (conv_chan),
        .conv_done_i   (conv_done),
        .conv_data_i   (conv_data),
        .out_valid_o   (out_valid),
        .out_data_o    (out_data),
        .out_last_o    (out_last),
        .out_ready_i   (out_ready),
        .overrun_cnt_o (ovr_cnt)
    );

    function automatic logic [15:0] samp(input int tag, input int ch);
        logic [7:0] t8;
        logic [2:0] c3;
        t8 = tag[7:0];
        c3 = ch[2:0];
        return {t8, 5'b10100, c3};
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Frame engine model
    initial forever begin
        @(negedge clk);
        #1;
        conv_done = 1'b0;
        if (conv_req) begin
            if (fe_wait >= fe_lat) begin
                check(int'(conv_chan) > last_chan, "R2 ascending order",
                      64'(conv_chan), 64'(last_chan + 1));
                last_chan = int'(conv_chan);
                conv_done = 1'b1;
                conv_data = samp(scan_tag, int'(conv_chan));
                req_count++;
                fe_wait = 0;
            end else begin
                fe_wait++;
            end
        end
    end

    // Monitor / scoreboard
    initial forever begin
        @(negedge clk);
        cyc++;
        out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        #1;
        if (hold_pend) begin
            check(out_valid && ({out_last, out_data} == hold_word), "R9 hold under backpressure",
                  64'({out_valid, out_last, out_data}), 64'({1'b1, hold_word}));
            hold_pend = 1'b0;
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected word", 64'({out_last, out_data}), 64'd0);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                check({out_last, out_data} == e, "R3/R4/R5 stream word",
                      64'({out_last, out_data}), 64'(e));
            end
        end else if (out_valid) begin
            hold_pend = 1'b1;
            hold_word = {out_last, out_data};
        end
    end

    // Watchdog
    initial begin
        wait (cyc > 150000);
        check(1'b0, "watchdog", 64'(cyc), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic wait_drain();
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, "record drained", 64'(exp_q.size()), 64'd0);
        repeat (12) @(negedge clk);
    endtask

    // Runs one scan; mid_mask is applied right after the trigger, extra_at > 0
    // issues a second trigger that many cycles later.
    task automatic run_scan(input logic [7:0] m, input logic [7:0] mid_mask, input int tag,
                            input int lat, input int extra_at, input string req);
        logic [63:0] t;
        logic [7:0]  ovr_before;
        scan_tag  = tag;
        fe_lat    = lat;
        fe_wait   = 0;
        req_count = 0;
        last_chan = -1;
        ovr_before = ovr_cnt;
        for (int ch = 0; ch < 8; ch++) begin
            if (m[ch]) exp_q.push_back({1'b0, samp(tag, ch)});
        end
        @(negedge clk);
        #1;
        chan_mask = m;
        trig = 1'b1;
        t = tstamp;
        for (int w = 0; w < 4; w++) begin
            exp_q.push_back({(w == 3), t[63 - 16*w -: 16]});
        end
        @(negedge clk);
        #1;
        trig = 1'b0;
        chan_mask = mid_mask;
        if (extra_at > 0) begin
            repeat (extra_at) @(negedge clk);
            #1;
            trig = 1'b1;
            @(negedge clk);
            #1;
            trig = 1'b0;
        end
        wait_drain();
        check(req_count == $countones(m), req, 64'(req_count), 64'($countones(m)));
        if (extra_at > 0)
            check(ovr_cnt == ovr_before + 8'd1, "R7 overrun count", 64'(ovr_cnt),
                  64'(ovr_before + 8'd1));
        else
            check(ovr_cnt == ovr_before, "R7 no overrun", 64'(ovr_cnt), 64'(ovr_before));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!out_valid, "R1 reset valid", 64'(out_valid), 64'd0);
        check(!conv_req, "R1 reset request", 64'(conv_req), 64'd0);
        check(ovr_cnt == 8'd0, "R1 reset overrun", 64'(ovr_cnt), 64'd0);

        rdy_mode = 0;
        run_scan(8'hFF, 8'hFF, 8'hA1, 0, 0, "R2 full mask requests");
        rdy_mode = 1;
        run_scan(8'hA5, 8'hA5, 8'h3C, 3, 0, "R2 sparse mask requests R10");
        run_scan(8'h00, 8'h00, 8'h11, 0, 0, "R6 empty mask no request");
        rdy_mode = 0;
        run_scan(8'h80, 8'h80, 8'hF0, 1, 0, "R2 top channel only");
        run_scan(8'h01, 8'h01, 8'h7E, 2, 0, "R2 bottom channel only");
        rdy_mode = 1;
        run_scan(8'h0F, 8'hF0, 8'h5A, 2, 0, "R8 mask latched at trigger");
        run_scan(8'h3C, 8'h3C, 8'hC3, 6, 4, "R7 trigger during scan");
        rdy_mode = 0;
        run_scan(8'h00, 8'hFF, 8'h22, 0, 2, "R6 R7 empty mask with overrun");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule